// File: doc/BRIEF.md
# Interrupt Dispatch Controller

The block gathers 64 level-sensitive interrupt lines and presents one of them at a time to the processor as a vector request. Lines 0 to 31 belong to expansion-bus slots and are gated in groups of four, with one mapping register per group. Lines 32 to 63 belong to on-board devices, and each has a mapping register of its own. Bit 31 of a mapping register is the enable bit. The remaining bits are a fixed identifier that reads back but never changes.

Inputs are sampled into a register on every clock. While no request is outstanding, the block scans the sampled lines every cycle and takes the lowest-numbered line that is both asserted and enabled. That request stays on the output until software removes it. It can do so through a clear register, or by writing a mapping register with the enable bit low. Other asserted lines cannot displace the outstanding request.

Top module: `irq_dispatch`

## Requirements
- R1: When idle, the block picks the lowest-numbered line that is asserted and enabled. Line i below 32 is enabled by bit 31 of slot mapping register i/4, at byte address 0xC00+8*(i/4). Line i from 32 up is enabled by bit 31 of on-board mapping register i-32, at byte address 0x1000+8*(i-32).
- R2: A write to a mapping register changes only bit 31. A read returns {enable, identifier}. The identifier of slot register g is 0x7C0|(4*g), and the identifier of on-board register k is 0x7E0+k.
- R3: Reset clears every enable bit and every sampled input. It also sets reqValid to 0 and reqVec to the idle code 64.
- R4: While a request is outstanding, reqVec and reqValid hold, whatever the other inputs do, until a clear or a withdrawal removes the request.
- R5: A write anywhere in 0x1400 to 0x14FF addresses group g=(addr&0xFF)>>5. It removes the request only when the request is a slot line whose number divided by 4 equals g. Otherwise it has no effect.
- R6: A write to 0x1800+8*k removes the request only when the request equals 32+k. Otherwise it has no effect.
- R7: If a mapping register is written with bit 31 at 0 while one of its lines is the outstanding request, the request is withdrawn.
- R8: A line asserted before clock edge n and enabled can become the request at edge n+1 at the earliest. A line that is disabled or deasserted never becomes a request.
- R9: Reads of the clear windows and of addresses outside all windows return 0. Writes outside all windows change nothing.
- R10: When a request is removed, the outputs show idle for exactly one cycle. Scanning then resumes on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 64 | Level interrupt lines, index = line number |
| regAddr | input | 16 | Register byte address |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data, only bit 31 is stored |
| regRdData | output | 32 | Read data for regAddr, combinational |
| reqValid | output | 1 | A request is outstanding |
| reqVec | output | 7 | Requested line number, 64 when idle |

## Verification
The bench uses the default parameters: eight slot groups of four lines and 32 on-board lines, which gives a 7-bit index with idle code 64. With this sizing the highest line (63), the last register of each mapping window, and the last clear group are all reachable. Both the group-based slot clear and the exact-match on-board clear can therefore be driven with wrong and right addresses against one outstanding request. Priority across the boundary between slot and on-board lines (31 against 32) is exercised directly.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  // widest register index a strobe can carry
  localparam int SEL_W = 8;
  // byte stride between mapping registers and its shift
  localparam int MAP_STRIDE = 8;
  localparam int STRIDE_SH = 3;
  // bit holding the enable in every mapping register
  localparam int EN_BIT = 31;
  // fixed identifier bases returned in bits 30:0
  localparam int PCI_ID_BASE = 32'h7C0;
  localparam int OB_ID_BASE = 32'h7E0;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_PCI  = 2'd1,
    RD_OB   = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic             pciMapWr;
    logic             obMapWr;
    logic             pciClr;
    logic             obClr;
    logic             enBit;
    logic [SEL_W-1:0] regIdx;
    rdSel_e           rdSel;
  } strobes_t;
endpackage

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int PCI_GROUPS      = 8,
  parameter int LINES_PER_GROUP = 4,
  parameter int OB_LINES        = 32,
  parameter int PCI_MAP_BASE    = 'h0C00,
  parameter int OB_MAP_BASE     = 'h1000,
  parameter int PCI_CLR_BASE    = 'h1400,
  parameter int OB_CLR_BASE     = 'h1800
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrEnBit,
  output strobes_t          stb
);
  localparam int GRP_STRIDE = MAP_STRIDE * LINES_PER_GROUP;
  localparam int GRP_SH     = $clog2(GRP_STRIDE);

  localparam logic [ADDR_W-1:0] PMAP_LO = ADDR_W'(PCI_MAP_BASE);
  localparam logic [ADDR_W-1:0] PMAP_HI = ADDR_W'(PCI_MAP_BASE + MAP_STRIDE * PCI_GROUPS);
  localparam logic [ADDR_W-1:0] OMAP_LO = ADDR_W'(OB_MAP_BASE);
  localparam logic [ADDR_W-1:0] OMAP_HI = ADDR_W'(OB_MAP_BASE + MAP_STRIDE * OB_LINES);
  localparam logic [ADDR_W-1:0] PCLR_LO = ADDR_W'(PCI_CLR_BASE);
  localparam logic [ADDR_W-1:0] PCLR_HI = ADDR_W'(PCI_CLR_BASE + GRP_STRIDE * PCI_GROUPS);
  localparam logic [ADDR_W-1:0] OCLR_LO = ADDR_W'(OB_CLR_BASE);
  localparam logic [ADDR_W-1:0] OCLR_HI = ADDR_W'(OB_CLR_BASE + MAP_STRIDE * OB_LINES);

  logic inPMap, inOMap, inPClr, inOClr;
  logic [ADDR_W-1:0] offPMap, offOMap, offPClr, offOClr;

  always_comb begin
    inPMap  = (regAddr >= PMAP_LO) && (regAddr < PMAP_HI);
    inOMap  = (regAddr >= OMAP_LO) && (regAddr < OMAP_HI);
    inPClr  = (regAddr >= PCLR_LO) && (regAddr < PCLR_HI);
    inOClr  = (regAddr >= OCLR_LO) && (regAddr < OCLR_HI);
    offPMap = regAddr - PMAP_LO;
    offOMap = regAddr - OMAP_LO;
    offPClr = regAddr - PCLR_LO;
    offOClr = regAddr - OCLR_LO;
  end

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    stb.enBit = wrEnBit;
    if (inPMap) begin
      stb.rdSel    = RD_PCI;
      stb.regIdx   = SEL_W'(offPMap >> STRIDE_SH);
      stb.pciMapWr = regWrEn;
    end else if (inOMap) begin
      stb.rdSel   = RD_OB;
      stb.regIdx  = SEL_W'(offOMap >> STRIDE_SH);
      stb.obMapWr = regWrEn;
    end else if (inPClr) begin
      stb.regIdx = SEL_W'(offPClr >> GRP_SH);
      stb.pciClr = regWrEn;
    end else if (inOClr) begin
      stb.regIdx = SEL_W'(offOClr >> STRIDE_SH);
      stb.obClr  = regWrEn;
    end
  end
endmodule

// File: rtl/irq_dispatch_dp.sv
module irq_dispatch_dp
  import irq_dispatch_pkg::*;
#(
  parameter int PCI_GROUPS      = 8,
  parameter int LINES_PER_GROUP = 4,
  parameter int OB_LINES        = 32,
  localparam int PCI_LINES      = PCI_GROUPS * LINES_PER_GROUP,
  localparam int NUM_LINES      = PCI_LINES + OB_LINES,
  localparam int IDX_W          = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  strobes_t             stb,
  output logic [31:0]          rdData,
  output logic                 reqValid,
  output logic [IDX_W-1:0]     reqVec
);
  localparam logic [IDX_W-1:0] IDLE = IDX_W'(NUM_LINES);

  logic [PCI_GROUPS-1:0] enPci;
  logic [OB_LINES-1:0]   enOb;
  logic [NUM_LINES-1:0]  lvl;
  logic [NUM_LINES-1:0]  lineEn;
  logic [NUM_LINES-1:0]  cand;
  logic [IDX_W-1:0]      reqIdx;
  logic [IDX_W-1:0]      pickIdx;
  logic [IDX_W-1:0]      reqNext;
  logic                  busy;
  logic                  reqIsPci;
  logic                  grpMatch;
  logic                  lineMatch;
  logic                  dropReq;

  // per-line enable: slot lines share a group register, on-board lines own one
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_lineEn
    if (g < PCI_LINES) begin : g_pci
      assign lineEn[g] = enPci[g / LINES_PER_GROUP];
    end else begin : g_ob
      assign lineEn[g] = enOb[g - PCI_LINES];
    end
  end

  assign cand = lvl & lineEn;

  // lowest asserted and enabled line wins
  always_comb begin
    pickIdx = IDLE;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) pickIdx = IDX_W'(i);
    end
  end

  // which removal conditions address the outstanding request
  always_comb begin
    busy      = (reqIdx != IDLE);
    reqIsPci  = (int'(reqIdx) < PCI_LINES);
    grpMatch  = busy && reqIsPci &&
                ((int'(reqIdx) / LINES_PER_GROUP) == int'(stb.regIdx));
    lineMatch = busy && (int'(reqIdx) == PCI_LINES + int'(stb.regIdx));
    dropReq   = (stb.pciClr && grpMatch) ||
                (stb.obClr && lineMatch) ||
                (stb.pciMapWr && !stb.enBit && grpMatch) ||
                (stb.obMapWr && !stb.enBit && lineMatch);
  end

  always_comb begin
    if (dropReq)    reqNext = IDLE;
    else if (!busy) reqNext = pickIdx;
    else            reqNext = reqIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqIdx <= IDLE;
      lvl    <= '0;
    end else begin
      reqIdx <= reqNext;
      lvl    <= irqIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPci <= '0;
      enOb  <= '0;
    end else begin
      for (int i = 0; i < PCI_GROUPS; i++) begin
        if (stb.pciMapWr && int'(stb.regIdx) == i) enPci[i] <= stb.enBit;
      end
      for (int i = 0; i < OB_LINES; i++) begin
        if (stb.obMapWr && int'(stb.regIdx) == i) enOb[i] <= stb.enBit;
      end
    end
  end

  // read mux: enable bit over the fixed identifier
  logic        rdEn;
  logic [30:0] rdLow;
  always_comb begin
    rdEn  = 1'b0;
    rdLow = '0;
    case (stb.rdSel)
      RD_PCI: begin
        for (int i = 0; i < PCI_GROUPS; i++) begin
          if (int'(stb.regIdx) == i) rdEn = enPci[i];
        end
        rdLow = 31'(PCI_ID_BASE | (int'(stb.regIdx) * LINES_PER_GROUP));
      end
      RD_OB: begin
        for (int i = 0; i < OB_LINES; i++) begin
          if (int'(stb.regIdx) == i) rdEn = enOb[i];
        end
        rdLow = 31'(OB_ID_BASE + int'(stb.regIdx));
      end
      default: ;
    endcase
    rdData = {rdEn, rdLow};
  end

  assign reqValid = busy;
  assign reqVec   = reqIdx;
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int PCI_GROUPS      = 8,
  parameter int LINES_PER_GROUP = 4,
  parameter int OB_LINES        = 32,
  parameter int PCI_MAP_BASE    = 'h0C00,
  parameter int OB_MAP_BASE     = 'h1000,
  parameter int PCI_CLR_BASE    = 'h1400,
  parameter int OB_CLR_BASE     = 'h1800,
  localparam int NUM_LINES      = PCI_GROUPS * LINES_PER_GROUP + OB_LINES,
  localparam int IDX_W          = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  output logic                 reqValid,
  output logic [IDX_W-1:0]     reqVec
);
  strobes_t stb;
  logic     unusedWrBits;

  // only the enable bit of write data is stored
  assign unusedWrBits = ^regWrData[EN_BIT-1:0];

  irq_dispatch_ctrl #(
    .ADDR_W(ADDR_W), .PCI_GROUPS(PCI_GROUPS), .LINES_PER_GROUP(LINES_PER_GROUP),
    .OB_LINES(OB_LINES), .PCI_MAP_BASE(PCI_MAP_BASE), .OB_MAP_BASE(OB_MAP_BASE),
    .PCI_CLR_BASE(PCI_CLR_BASE), .OB_CLR_BASE(OB_CLR_BASE)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .wrEnBit(regWrData[EN_BIT]),
    .stb(stb)
  );

  irq_dispatch_dp #(
    .PCI_GROUPS(PCI_GROUPS), .LINES_PER_GROUP(LINES_PER_GROUP), .OB_LINES(OB_LINES)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .irqIn(irqIn),
    .stb(stb),
    .rdData(regRdData),
    .reqValid(reqValid),
    .reqVec(reqVec)
  );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 regWrEn,
  input logic                 reqValid,
  input logic [IDX_W-1:0]     reqVec
);
  // R3
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!reqValid && int'(reqVec) == NUM_LINES));

  // R4
  hold_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !regWrEn) |=> (reqValid && $stable(reqVec)));

  // R4
  new_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !$stable(reqVec)) |-> !$past(reqValid));

  // R1
  index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (int'(reqVec) < NUM_LINES));

  // R8
  source_asserted_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> (|($past(irqIn, 2) & (NUM_LINES'(1) << reqVec))));
endmodule

bind irq_dispatch irq_dispatch_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .irqIn(irqIn),
  .regWrEn(regWrEn),
  .reqValid(reqValid),
  .reqVec(reqVec)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int  IDLE = 64;
  localparam logic [31:0] EN = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] irqIn;
  logic [15:0] regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        reqValid;
  logic [6:0]  reqVec;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  irq_dispatch dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .reqValid(reqValid), .reqVec(reqVec)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [15:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setLines(input logic [63:0] v);
    @(negedge clk);
    irqIn = v;
  endtask

  task automatic expReq(input string tag, input bit v, input int idx);
    chk(tag, 32'({reqValid, reqVec}), 32'({v, 7'(idx)}));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    expReq("R3 idle after reset", 1'b0, IDLE);
    readReg(16'h0C18, d); chk("R3/R2 slot reg3 reset", d, 32'h0000_07CC);
    readReg(16'h10A8, d); chk("R3/R2 onboard reg21 reset", d, 32'h0000_07F5);
  endtask

  task automatic t_mapWrite;
    logic [31:0] d;
    writeReg(16'h0C18, 32'hFFFF_FFFF);
    readReg(16'h0C18, d); chk("R2 set enable only", d, 32'h8000_07CC);
    writeReg(16'h0C18, 32'h7FFF_FFFF);
    readReg(16'h0C18, d); chk("R2 clear enable only", d, 32'h0000_07CC);
    writeReg(16'h10F8, 32'h8000_1234);
    readReg(16'h10F8, d); chk("R2 onboard reg31", d, 32'h8000_07FF);
    writeReg(16'h10F8, 32'h0);
  endtask

  task automatic t_pciFlow;
    writeReg(16'h0C10, EN);
    setLines(64'(1) << 9);
    cycles(1); expReq("R8 not yet after one edge", 1'b0, IDLE);
    cycles(1); expReq("R1 slot line 9", 1'b1, 9);
    writeReg(16'h0C00, EN);
    setLines((64'(1) << 9) | (64'(1) << 1));
    cycles(3); expReq("R4 held despite lower line", 1'b1, 9);
    writeReg(16'h1420, 32'h0); expReq("R5 wrong group ignored", 1'b1, 9);
    writeReg(16'h1440, 32'h0); expReq("R5 group clear", 1'b0, IDLE);
    cycles(1); expReq("R10 rescan picks lowest", 1'b1, 1);
    writeReg(16'h0C00, 32'h0); expReq("R7 slot withdraw", 1'b0, IDLE);
    cycles(1); expReq("R10 rescan after withdraw", 1'b1, 9);
    setLines(64'h0);
    writeReg(16'h1440, 32'h0);
    cycles(3); expReq("R8 no lines no request", 1'b0, IDLE);
    setLines(64'(1) << 20);
    cycles(3); expReq("R8 disabled line ignored", 1'b0, IDLE);
    setLines(64'h0);
    writeReg(16'h0C10, 32'h0);
  endtask

  task automatic t_obFlow;
    writeReg(16'h10F8, EN);
    setLines(64'(1) << 63);
    cycles(2); expReq("R1 onboard line 63", 1'b1, 63);
    writeReg(16'h1800, 32'h0); expReq("R6 wrong line ignored", 1'b1, 63);
    writeReg(16'h14E0, 32'h0); expReq("R5 group clear misses onboard", 1'b1, 63);
    writeReg(16'h18F8, 32'h0); expReq("R6 exact clear", 1'b0, IDLE);
    cycles(1); expReq("R10 onboard rescan", 1'b1, 63);
    writeReg(16'h10F8, 32'h0); expReq("R7 onboard withdraw", 1'b0, IDLE);
    cycles(2); expReq("R7 stays idle when disabled", 1'b0, IDLE);
    setLines(64'h0);
  endtask

  task automatic t_prio;
    writeReg(16'h1000, EN);
    writeReg(16'h0C38, EN);
    setLines((64'(1) << 31) | (64'(1) << 32));
    cycles(2); expReq("R1 line 31 beats 32", 1'b1, 31);
    setLines(64'h0);
    writeReg(16'h14E0, 32'h0); expReq("R5 last group clear", 1'b0, IDLE);
    writeReg(16'h1000, 32'h0);
    writeReg(16'h0C38, 32'h0);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    writeReg(16'h0C10, EN);
    setLines(64'(1) << 9);
    cycles(2); expReq("R1 line 9 again", 1'b1, 9);
    writeReg(16'h2000, 32'h0);
    writeReg(16'h0C40, 32'h0); expReq("R9 outside writes ignored", 1'b1, 9);
    readReg(16'h0C10, d); chk("R9 map unchanged", d, 32'h8000_07C8);
    readReg(16'h2000, d); chk("R9 outside read zero", d, 32'h0);
    readReg(16'h1440, d); chk("R9 clear window reads zero", d, 32'h0);
    readReg(16'h1808, d); chk("R9 onboard clear reads zero", d, 32'h0);
  endtask

  task automatic t_resetMid;
    logic [31:0] d;
    @(negedge clk); rstN = 1'b0;
    cycles(2); rstN = 1'b1;
    expReq("R3 mid-run reset idle", 1'b0, IDLE);
    readReg(16'h0C10, d); chk("R3 enable cleared", d, 32'h0000_07C8);
    cycles(3); expReq("R3 stays idle, enable gone", 1'b0, IDLE);
    setLines(64'h0);
  endtask

  initial begin
    rstN = 1'b0; irqIn = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    t_reset();
    t_mapWrite();
    t_pciFlow();
    t_obFlow();
    t_prio();
    t_misc();
    t_resetMid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule